// File: doc/BRIEF.md
# Front-End Master-Mode Startup Sequencer

This block takes an imaging analog front-end from power-up into master-mode operation. After a start pulse it issues a fixed, ordered series of register writes on a write-request port. The port has an 8-bit address, a data word and a valid/ready handshake. The sequencer also drives the combined reset/sync pin and the vertical-driver enable.

Between some steps it holds off for minimum times given in microseconds and nanoseconds. It turns each time into clock cycles from a clock-frequency parameter and always rounds up, so no hold-off ever comes out short. Three configuration inputs add or change optional steps:
- a three-phase horizontal clock mode;
- a double-rate input clock;
- a choice between a hardware sync pulse and a software sync write.

A small table of user timing registers is computed at elaboration time and written in the middle of the sequence. The serial link that carries the writes, supply control and the timing generator itself lie outside this block.

Top module: `fe_startup_seq`

## Requirements
- R1: After reset and until the first start pulse, the reset/sync pin is low, the driver enable is low, no write is requested and done is low.
- R2: A start pulse drives the pin high. The first write is presented no earlier than PIN_SETUP_CYC cycles later. The pin stays high for every write and, apart from the sync pulse of R11, for the rest of the sequence.
- R3: Writes (address = data, hex) go out in this order: 12=0, 10=1, 25=1FF8000, 26=1FF8000, 1C=FF8000, D1=100000, [R4], 00=04, [R5], 14=1, [R8], 11=1, 20=1, [R11].
- R4: When the three-phase input is high at the start pulse, 24=10 is inserted between D1 and 00; otherwise it is absent. All three configuration inputs are captured at the start pulse only; later changes have no effect on the running sequence.
- R5: When the double-rate clock input is high at start, 0D=1 is written right before 14; otherwise it is absent.
- R6: The next write after 00 is accepted is presented no sooner than ceil(500 µs × CLK_HZ) cycles later.
- R7: The next write after 14 is accepted is presented no sooner than ceil(100 µs × CLK_HZ) cycles later.
- R8: After the R7 wait, N_USER user writes follow: entry i goes to address USER_BASE+i with data (i+1)×0x010203, for i rising from 0.
- R9: The driver enable stays low through acceptance of the 14 write. It rises only after the last user write is accepted and before 11 is presented. It then stays high until the next start pulse.
- R10: A presented write keeps valid, address and data unchanged until ready is seen.
- R11: With hardware sync selected, the pin goes low after 20 is accepted, stays low for at least ceil(100 ns × CLK_HZ) cycles (minimum one), then returns high, and no 13 write occurs. With software sync, 13=1000000 (bit 24 set) is written after 20 and the pin stays high.
- R12: Done rises once the sync step has finished and stays high with no further writes. A start pulse at any point restarts from the first write with done and driver enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts or restarts the sequence |
| cfg_three_phase_i | input | 1 | Select three-phase horizontal clock mode (extra write) |
| cfg_double_clk_i | input | 1 | Input clock runs at double rate (extra write) |
| cfg_hw_sync_i | input | 1 | 1: sync by pin pulse, 0: sync by register write |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted by the link |
| wr_addr_o | output | 8 | Register address |
| wr_data_o | output | DATA_W | Register data |
| rst_sync_n_o | output | 1 | Reset/sync pin, low active |
| vdrv_en_o | output | 1 | Vertical-driver enable |
| done_o | output | 1 | Sequence complete |

## Verification
The hardest state to reach is a restart in the middle of the long front-end hold-off. By then the design has latched one configuration, several writes have gone out, and no write is pending. The bench starts one sequence and follows the accepted writes until the 00 write completes. It waits a further stretch inside the hold-off and then pulses start with a different configuration. Every write after that must match a freshly built expected list from 12 onward. The configuration inputs are also inverted on the cycle after each start, and ready is stalled by a pseudo-random pattern, so that latching and the hold of a pending write are both exercised.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

   typedef enum logic [2:0] {
      OP_SKIP,
      OP_WRITE,
      OP_WAIT,
      OP_DRV,
      OP_PULSE,
      OP_END
   } op_kind_e;

   typedef enum logic [1:0] {
      WT_NONE,
      WT_FE,
      WT_CORE
   } wait_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_FETCH,
      ST_WRITE,
      ST_WAIT,
      ST_SYNC_LO,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      op_kind_e   kind;
      wait_sel_e  wsel;
      logic [7:0] addr;
   } step_t;

   typedef struct packed {
      logic three_phase;
      logic double_clk;
      logic hw_sync;
   } cfg_t;

   function automatic longint unsigned ceil_div(longint unsigned num, longint unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic logic [31:0] user_value(int unsigned idx);
      return 32'((idx + 1) * 32'h0001_0203);
   endfunction

endpackage

// File: rtl/fsu_hold_timer.sv
module fsu_hold_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] len_i,
   output logic         expire_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= len_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign expire_o = (cnt_q == W'(1));

   AST_TMR_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - W'(1))); // R6

   AST_TMR_NONZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (len_i != '0)); // R11

endmodule

// File: rtl/fsu_wr_port.sv
module fsu_wr_port #(
   parameter int DATA_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              load_i,
   input  logic [7:0]        addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [7:0]        addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              fire_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
         data_o  <= '0;
      end else if (flush_i) begin
         valid_o <= 1'b0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         addr_o  <= addr_i;
         data_o  <= data_i;
      end else if (fire_o) begin
         valid_o <= 1'b0;
      end
   end

   assign fire_o = valid_o & ready_i;

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i && !flush_i) |=> (valid_o && $stable(addr_o) && $stable(data_o))); // R10

   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !valid_o); // R10

endmodule

// File: rtl/fsu_step_rom.sv
module fsu_step_rom
   import fsu_pkg::*;
#(
   parameter int         DATA_W    = 28,
   parameter int         N_USER    = 4,
   parameter logic [7:0] USER_BASE = 8'h40,
   parameter int         PC_W      = 5
) (
   input  logic [PC_W-1:0]   pc_i,
   input  cfg_t              cfg_i,
   output step_t             step_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int USER_LO = 12;
   localparam int USER_HI = USER_LO + N_USER;

   logic [7:0]  u_addr [N_USER];
   logic [31:0] u_val  [N_USER];

   for (genvar g = 0; g < N_USER; g++) begin : g_user
      assign u_addr[g] = USER_BASE + 8'(g);
      assign u_val[g]  = user_value(g);
   end

   logic [31:0] dval;
   int          pc_int;

   always_comb begin
      pc_int = int'(pc_i);
      step_o = '{kind: OP_END, wsel: WT_NONE, addr: 8'h00};
      dval   = '0;
      if (pc_int < USER_LO) begin
         step_o.kind = OP_WRITE;
         case (pc_int)
            0:  begin step_o.addr = 8'h12; dval = 32'h0; end          // pin becomes sync
            1:  begin step_o.addr = 8'h10; dval = 32'h1; end          // software reset
            2:  begin step_o.addr = 8'h25; dval = 32'h01FF_8000; end
            3:  begin step_o.addr = 8'h26; dval = 32'h01FF_8000; end
            4:  begin step_o.addr = 8'h1C; dval = 32'h00FF_8000; end
            5:  begin step_o.addr = 8'hD1; dval = 32'h0010_0000; end
            6:  begin
               if (cfg_i.three_phase) begin step_o.addr = 8'h24; dval = 32'h10; end
               else step_o.kind = OP_SKIP;
            end
            7:  begin step_o.addr = 8'h00; dval = 32'h4; end          // front-end on, clamp on
            8:  begin step_o.kind = OP_WAIT; step_o.wsel = WT_FE; end
            9:  begin
               if (cfg_i.double_clk) begin step_o.addr = 8'h0D; dval = 32'h1; end
               else step_o.kind = OP_SKIP;
            end
            10: begin step_o.addr = 8'h14; dval = 32'h1; end          // timing core reset
            default: begin step_o.kind = OP_WAIT; step_o.wsel = WT_CORE; end
         endcase
      end else if (pc_int < USER_HI) begin
         step_o.kind = OP_WRITE;
         for (int k = 0; k < N_USER; k++) begin
            if (pc_int == USER_LO + k) begin
               step_o.addr = u_addr[k];
               dval        = u_val[k];
            end
         end
      end else begin
         case (pc_int - USER_HI)
            0: step_o.kind = OP_DRV;
            1: begin step_o.kind = OP_WRITE; step_o.addr = 8'h11; dval = 32'h1; end
            2: begin step_o.kind = OP_WRITE; step_o.addr = 8'h20; dval = 32'h1; end
            3: begin
               if (cfg_i.hw_sync) step_o.kind = OP_PULSE;
               else begin step_o.kind = OP_WRITE; step_o.addr = 8'h13; dval = 32'h0100_0000; end
            end
            default: step_o.kind = OP_END;
         endcase
      end
   end

   assign data_o = DATA_W'(dval);

endmodule

// File: rtl/fe_startup_seq.sv
module fe_startup_seq
   import fsu_pkg::*;
#(
   parameter int unsigned CLK_HZ        = 100_000_000,
   parameter int          DATA_W        = 28,
   parameter int          N_USER        = 4,
   parameter logic [7:0]  USER_BASE     = 8'h40,
   parameter int          PIN_SETUP_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cfg_three_phase_i,
   input  logic              cfg_double_clk_i,
   input  logic              cfg_hw_sync_i,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [7:0]        wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              rst_sync_n_o,
   output logic              vdrv_en_o,
   output logic              done_o
);

   localparam longint unsigned FE_CYC   = ceil_div(64'(CLK_HZ) * 64'd500, 64'd1_000_000);
   localparam longint unsigned CORE_CYC = ceil_div(64'(CLK_HZ) * 64'd100, 64'd1_000_000);
   localparam longint unsigned SYNC_RAW = ceil_div(64'(CLK_HZ) * 64'd100, 64'd1_000_000_000);
   localparam longint unsigned SYNC_CYC = (SYNC_RAW == 0) ? 64'd1 : SYNC_RAW;
   localparam longint unsigned MAX_CYC  = (FE_CYC > 64'(PIN_SETUP_CYC)) ? FE_CYC : 64'(PIN_SETUP_CYC);
   localparam int              TW       = $clog2(MAX_CYC + 1);
   localparam int              N_SLOT   = 17 + N_USER;
   localparam int              PC_W     = $clog2(N_SLOT + 1);

   localparam logic [TW-1:0] FE_LEN    = TW'(FE_CYC);
   localparam logic [TW-1:0] CORE_LEN  = TW'(CORE_CYC);
   localparam logic [TW-1:0] SYNC_LEN  = TW'(SYNC_CYC);
   localparam logic [TW-1:0] SETUP_LEN = TW'(PIN_SETUP_CYC);

   if (DATA_W < 25 || DATA_W > 32) begin : g_bad_data_w
      $error("DATA_W must lie in 25..32 to carry the widest register value");
   end
   if (N_USER < 1 || N_USER > 64) begin : g_bad_n_user
      $error("N_USER must lie in 1..64");
   end
   if (PIN_SETUP_CYC < 1) begin : g_bad_setup
      $error("PIN_SETUP_CYC must be at least 1");
   end
   if (CLK_HZ < 1_000_000) begin : g_bad_clk
      $error("CLK_HZ below 1 MHz is not supported");
   end
   if (32'(USER_BASE) + 32'(N_USER) > 256) begin : g_bad_base
      $error("user register block runs past address 0xFF");
   end

   seq_state_e        st_q;
   logic [PC_W-1:0]   pc_q;
   cfg_t              cfg_q;
   step_t             step;
   logic [DATA_W-1:0] step_data;
   logic              tmr_load, tmr_exp, wr_load, wr_fire;
   logic [TW-1:0]     tmr_len;

   fsu_step_rom #(
      .DATA_W    (DATA_W),
      .N_USER    (N_USER),
      .USER_BASE (USER_BASE),
      .PC_W      (PC_W)
   ) i_rom (
      .pc_i   (pc_q),
      .cfg_i  (cfg_q),
      .step_o (step),
      .data_o (step_data)
   );

   fsu_hold_timer #(.W(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .len_i    (tmr_len),
      .expire_o (tmr_exp)
   );

   fsu_wr_port #(.DATA_W(DATA_W)) i_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (start_i),
      .load_i  (wr_load),
      .addr_i  (step.addr),
      .data_i  (step_data),
      .ready_i (wr_ready_i),
      .valid_o (wr_valid_o),
      .addr_o  (wr_addr_o),
      .data_o  (wr_data_o),
      .fire_o  (wr_fire)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_len  = '0;
      wr_load  = 1'b0;
      if (start_i) begin
         tmr_load = 1'b1;
         tmr_len  = SETUP_LEN;
      end else if (st_q == ST_FETCH) begin
         case (step.kind)
            OP_WRITE: wr_load = 1'b1;
            OP_WAIT: begin
               tmr_load = 1'b1;
               tmr_len  = (step.wsel == WT_FE) ? FE_LEN : CORE_LEN;
            end
            OP_PULSE: begin
               tmr_load = 1'b1;
               tmr_len  = SYNC_LEN;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         pc_q         <= '0;
         cfg_q        <= '0;
         rst_sync_n_o <= 1'b0;
         vdrv_en_o    <= 1'b0;
         done_o       <= 1'b0;
      end else if (start_i) begin
         st_q         <= ST_SETUP;
         pc_q         <= '0;
         cfg_q        <= '{three_phase: cfg_three_phase_i,
                           double_clk:  cfg_double_clk_i,
                           hw_sync:     cfg_hw_sync_i};
         rst_sync_n_o <= 1'b1;
         vdrv_en_o    <= 1'b0;
         done_o       <= 1'b0;
      end else begin
         case (st_q)
            ST_SETUP: if (tmr_exp) st_q <= ST_FETCH;
            ST_FETCH: begin
               case (step.kind)
                  OP_SKIP:  pc_q <= pc_q + PC_W'(1);
                  OP_WRITE: st_q <= ST_WRITE;
                  OP_WAIT:  st_q <= ST_WAIT;
                  OP_DRV: begin
                     vdrv_en_o <= 1'b1;
                     pc_q      <= pc_q + PC_W'(1);
                  end
                  OP_PULSE: begin
                     rst_sync_n_o <= 1'b0;
                     st_q         <= ST_SYNC_LO;
                  end
                  default: begin
                     done_o <= 1'b1;
                     st_q   <= ST_DONE;
                  end
               endcase
            end
            ST_WRITE: if (wr_fire) begin
               pc_q <= pc_q + PC_W'(1);
               st_q <= ST_FETCH;
            end
            ST_WAIT: if (tmr_exp) begin
               pc_q <= pc_q + PC_W'(1);
               st_q <= ST_FETCH;
            end
            ST_SYNC_LO: if (tmr_exp) begin
               rst_sync_n_o <= 1'b1;
               pc_q         <= pc_q + PC_W'(1);
               st_q         <= ST_FETCH;
            end
            default: ;
         endcase
      end
   end

   AST_PIN_HIGH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> rst_sync_n_o); // R2

   AST_DRV_LOW_AT_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && wr_addr_o == 8'h14) |-> !vdrv_en_o); // R9

   AST_DRV_HIGH_AT_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && wr_addr_o == 8'h11) |-> vdrv_en_o); // R9

   AST_DRV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (vdrv_en_o && !start_i) |=> vdrv_en_o); // R9

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rst_sync_n_o && vdrv_en_o && !wr_valid_o)); // R12

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !vdrv_en_o && rst_sync_n_o && !wr_valid_o)); // R12

endmodule

// File: tb/test_fe_startup_seq.sv
module test_fe_startup_seq;

   localparam int          CLK_P  = 10;
   localparam int unsigned HZ     = 20_000_000;
   localparam int          DW     = 28;
   localparam int          NU     = 4;
   localparam logic [7:0]  UB     = 8'h40;
   localparam int          SETUP  = 4;
   localparam longint      N_FE   = (longint'(HZ) * 500 + 999_999) / 1_000_000;
   localparam longint      N_CORE = (longint'(HZ) * 100 + 999_999) / 1_000_000;
   localparam longint      N_SYNC = (longint'(HZ) * 100 + 999_999_999) / 1_000_000_000;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic c3 = 1'b0, cd = 1'b0, chw = 1'b0, rdy = 1'b0;
   logic valid, pin, vdrv, done;
   logic [7:0] addr;
   logic [DW-1:0] data;

   always #(CLK_P/2) clk = ~clk;

   fe_startup_seq #(
      .CLK_HZ(HZ), .DATA_W(DW), .N_USER(NU), .USER_BASE(UB), .PIN_SETUP_CYC(SETUP)
   ) i_fe_startup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .cfg_three_phase_i(c3), .cfg_double_clk_i(cd), .cfg_hw_sync_i(chw),
      .wr_valid_o(valid), .wr_ready_i(rdy), .wr_addr_o(addr), .wr_data_o(data),
      .rst_sync_n_o(pin), .vdrv_en_o(vdrv), .done_o(done)
   );

   int checks = 0, errors = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model state
   logic [39:0] expq [$];
   logic [39:0] e;
   bit     run_act = 0, hw_m = 0, stall = 0;
   bit     first_seen, after_fe, after_core, after_20, pulse_done;
   longint cyc = 0, t_pin, t_fe, t_core, low_cnt;
   bit     p_valid = 0, p_rdy = 0, p_vdrv = 0, p_done = 0;
   logic [7:0]    p_addr = '0;
   logic [DW-1:0] p_data = '0;

   function automatic string req_of(logic [7:0] a);
      if (a == 8'h24) return "R4";
      if (a == 8'h0D) return "R5";
      if (a == 8'h13) return "R11";
      if (a >= UB && a < UB + 8'(NU)) return "R8";
      return "R3";
   endfunction

   task automatic push(logic [7:0] a, logic [31:0] d);
      expq.push_back({a, d});
   endtask

   task automatic arm(bit t3, bit dc, bit hw);
      expq.delete();
      push(8'h12, 32'h0); push(8'h10, 32'h1);
      push(8'h25, 32'h01FF_8000); push(8'h26, 32'h01FF_8000);
      push(8'h1C, 32'h00FF_8000); push(8'hD1, 32'h0010_0000);
      if (t3) push(8'h24, 32'h10);
      push(8'h00, 32'h4);
      if (dc) push(8'h0D, 32'h1);
      push(8'h14, 32'h1);
      for (int i = 0; i < NU; i++) push(UB + 8'(i), 32'((i + 1) * 32'h0001_0203));
      push(8'h11, 32'h1); push(8'h20, 32'h1);
      if (!hw) push(8'h13, 32'h0100_0000);
      hw_m = hw; run_act = 1;
      first_seen = 0; after_fe = 0; after_core = 0; after_20 = 0; pulse_done = 0;
      t_pin = -1; t_fe = 0; t_core = 0; low_cnt = 0;
   endtask

   // ready pattern
   logic [15:0] lfsr = 16'hACE1;
   initial forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy  = stall ? (lfsr[0] | lfsr[5]) : 1'b1;
   end

   // per-cycle comparison against the model, sampled before each rising edge
   initial forever begin
      @(negedge clk);
      #(CLK_P/4);
      cyc++;
      if (run_act && !start) begin
         if (pin && t_pin < 0) t_pin = cyc;
         if (!pin) begin
            if (hw_m && after_20 && !pulse_done) low_cnt++;
            else chk(0, "R2", "pin low during sequence", 0, 1);
         end else if (low_cnt > 0 && !pulse_done) begin
            pulse_done = 1;
            chk(low_cnt >= N_SYNC, "R11", "sync low width", low_cnt, N_SYNC);
         end
         if (valid && !p_valid) begin
            if (!first_seen) begin
               first_seen = 1;
               chk(cyc - t_pin >= SETUP, "R2", "pin setup before first write", cyc - t_pin, SETUP);
            end
            if (after_fe) begin
               after_fe = 0;
               chk(cyc - t_fe >= N_FE, "R6", "front-end hold-off", cyc - t_fe, N_FE);
            end
            if (after_core) begin
               after_core = 0;
               chk(cyc - t_core >= N_CORE, "R7", "core hold-off", cyc - t_core, N_CORE);
            end
         end
         if (p_valid && !p_rdy)
            chk(valid && addr == p_addr && data == p_data, "R10", "write held until ready",
                {valid, addr, 32'(data)}, {1'b1, p_addr, 32'(p_data)});
         if (valid && addr == 8'h11)
            chk(vdrv, "R9", "driver enable at output-enable write", vdrv, 1);
         if (valid && rdy) begin
            if (expq.size() == 0) chk(0, "R12", "unexpected write", addr, 0);
            else begin
               e = expq.pop_front();
               chk({addr, 32'(data)} == e, req_of(e[39:32]), "write addr/data",
                   {addr, 32'(data)}, e);
            end
            if (addr == 8'h00) begin after_fe = 1; t_fe = cyc; end
            if (addr == 8'h14) begin
               after_core = 1; t_core = cyc;
               chk(!vdrv, "R9", "driver enable low at core reset", vdrv, 0);
            end
            if (addr == 8'h20) after_20 = 1;
         end
         if (vdrv && !p_vdrv)
            chk(expq.size() > 0 && expq[0][39:32] == 8'h11 && !after_core, "R9",
                "driver enable rise point", expq.size(), 0);
         if (done && !p_done)
            chk(expq.size() == 0 && pin && vdrv && (!hw_m || pulse_done), "R12",
                "done with sequence complete", {expq.size(), pin, vdrv}, 3);
      end
      p_valid = run_act && valid; p_rdy = rdy; p_addr = addr; p_data = data;
      p_vdrv = vdrv; p_done = done;
   end

   task automatic kick(bit t3, bit dc, bit hw, bit st);
      @(negedge clk);
      c3 = t3; cd = dc; chw = hw; stall = st; start = 1'b1;
      arm(t3, dc, hw);
      @(negedge clk);
      start = 1'b0;
      c3 = ~t3; cd = ~dc; chw = ~hw;   // later changes must not matter (R4)
   endtask

   task automatic run(bit t3, bit dc, bit hw, bit st);
      kick(t3, dc, hw, st);
      while (!done) @(negedge clk);
      repeat (12) begin
         @(negedge clk);
         chk(done && !valid && pin && vdrv, "R12", "done holds, no writes",
             {done, valid, pin, vdrv}, 4'b1011);
      end
      chk(expq.size() == 0, "R3", "all expected writes issued", expq.size(), 0);
   endtask

   initial begin
      repeat (20000 * 19 / 2) @(posedge clk);
      checks++; errors++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) begin
         @(negedge clk);
         chk(!pin && !vdrv && !valid && !done, "R1", "idle after reset",
             {pin, vdrv, valid, done}, 0);
      end
      run(1'b0, 1'b0, 1'b1, 1'b0);
      run(1'b1, 1'b1, 1'b1, 1'b1);
      run(1'b1, 1'b0, 1'b0, 1'b1);
      run(1'b0, 1'b1, 1'b0, 1'b0);
      // restart inside the front-end hold-off
      kick(1'b0, 1'b1, 1'b1, 1'b0);
      while (!after_fe) @(negedge clk);
      repeat (200) @(negedge clk);
      chk(!vdrv && !done && !valid && pin, "R12", "mid-wait state before restart",
          {vdrv, done, valid, pin}, 1);
      run(1'b1, 1'b0, 1'b0, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule